// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block turns bytes into asynchronous serial frames on a single output line. Bytes are written into a small queue. The serializer takes them one at a time and sends a start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two stop bits. A free-running divisor counter produces a tick at 16 times the bit rate. Each bit lasts 16 ticks. A 7-bit frame configuration word sets the data length, stop count, parity mode and the break request.

Break holds the line at 0. A break request is latched. It begins once every byte already queued has gone out. It lasts at least one full frame time, even if the request bit is dropped one clock after it was raised. While break is requested, pending or active, any byte written is dropped. Two flags report whether the queue is empty and whether the whole transmitter is idle.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset the line is 1, and both `txq_empty_o` and `tx_idle_o` are 1.
- R2: Each transmitted bit lasts 16 × `divisor_i` clocks. A divisor of 0 is treated as 1.
- R3: A frame consists of a start bit of 0, then the data bits least significant bit first, then the stop bits at 1. The data length is `frame_cfg_i[1:0]` + 5. There are two stop bits when `frame_cfg_i[2]` is 1 and one otherwise. The idle line is 1.
- R4: When `frame_cfg_i[3]` is 1, a parity bit follows the data. `frame_cfg_i[4]` selects even parity. If `frame_cfg_i[5]` (stick) is also 1, the parity bit is the inverse of `frame_cfg_i[4]`. Otherwise it makes the count of ones in data plus parity even (bit 4 = 1) or odd (bit 4 = 0).
- R5: `txq_empty_o` is 1 exactly when the queue holds no byte. `tx_idle_o` is 1 only when the queue is empty and no frame or break is on the line. While `tx_idle_o` is 1, the line is 1.
- R6: The queue holds `FIFO_DEPTH` bytes (4 by default) and sends them in write order. A write to a full queue is dropped.
- R7: Setting `frame_cfg_i[6]` requests a break. Bytes queued before the request are sent first. The line is then held at 0 for as long as the bit stays set, and the break ends on a bit boundary.
- R8: A break lasts at least one frame time: (1 + data length + parity + stop count) × 16 bit-ticks, using the configuration at the moment the break starts. This holds even when `frame_cfg_i[6]` was set for a single clock.
- R9: A byte written while `frame_cfg_i[6]` is set, or while a break is pending or active, is discarded. It never appears on the line and leaves `txq_empty_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| divisor_i | input | DIV_W | Clocks per 16x tick |
| frame_cfg_i | input | 7 | [1:0] length−5, [2] two stops, [3] parity on, [4] even, [5] stick, [6] break |
| wr_en_i | input | 1 | Write strobe for one byte |
| wr_data_i | input | 8 | Byte to send |
| txd_o | output | 1 | Serial line |
| txq_empty_o | output | 1 | Queue empty |
| tx_idle_o | output | 1 | Queue empty and line idle |

## Verification
The assertions assume that `wr_en_i` is a one-cycle strobe. They also assume that the break bit is driven as a level that may be dropped at any time. They make no assumption about when the divisor changes. Because the divisor can move its tick phase, the bench changes `divisor_i` only while `tx_idle_o` is 1. The bench times every frame from the falling edge of the start bit, so its expectations do not depend on the tick phase at the moment of the write. Frame format is latched at frame start. Break length is latched at break start. The bench changes `frame_cfg_i` only between frames, except for the deliberate one-clock break pulses.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers for the serial transmitter.
// Assumes an 8-bit data path; frame length is at most 12 bits.
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BREAK
    } tx_state_e;

    typedef struct packed {
        logic       brk;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] len_sel;
    } frame_cfg_t;

    // Unpack the raw configuration word into named fields
    function automatic frame_cfg_t decode_cfg(input logic [6:0] raw);
        frame_cfg_t c;
        c.len_sel  = raw[1:0];
        c.two_stop = raw[2];
        c.par_en   = raw[3];
        c.even     = raw[4];
        c.stick    = raw[5];
        c.brk      = raw[6];
        return c;
    endfunction

    // Total bits in one frame: start + data + parity + stops
    function automatic logic [3:0] frame_bits(input frame_cfg_t c);
        return 4'd7 + {2'b00, c.len_sel} + {3'b000, c.par_en} + {3'b000, c.two_stop};
    endfunction

    // Parity bit for the configured data length and mode
    function automatic logic parity_of(input frame_cfg_t c, input logic [7:0] d);
        logic [7:0] m;
        case (c.len_sel)
            2'd0:    m = d & 8'h1F;
            2'd1:    m = d & 8'h3F;
            2'd2:    m = d & 8'h7F;
            default: m = d;
        endcase
        if (c.stick) return ~c.even;
        return (^m) ^ ~c.even;
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
// Divisor counter: pulses tick_o once every divisor_i clocks (16x bit rate).
// Assumes a divisor of 0 means 1; a divisor shrink mid-count ends the count at once.
module uart_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // Terminal count derived from the divisor
    always_comb limit = (divisor_i == '0) ? '0 : divisor_i - DIV_W'(1);

    assign tick_o = (cnt_q >= limit);

    // Free-running count, restarted on every tick
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/uart_tx_fifo.sv
// Show-ahead byte queue between the write port and the serializer.
// Assumes push is gated by the caller when full; pop only when not empty.
module uart_tx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]     count_q;

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CW'(DEPTH));
    assign dout_o  = mem[rd_ptr_q];

    // Storage write, one slot per accepted byte
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr_q] <= din_i;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_i)
                wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
            if (pop_i)
                rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
            case ({push_i, pop_i})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_shift.sv
// Frame serializer and break generator, advancing once per 16x tick.
// Assumes frame format is latched at frame start; break waits for the queue to drain.
module uart_tx_shift
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [6:0] cfg_i,
    input  logic       q_empty_i,
    input  logic [7:0] q_data_i,
    output logic       pop_o,
    output logic       txd_o,
    output logic       idle_o,
    output logic       block_o
);
    localparam logic [3:0] LAST_SUB = 4'd15;

    tx_state_e  state_q;
    frame_cfg_t cur, cfg_q;
    logic [3:0] sub_q;
    logic [3:0] bit_q;
    logic [3:0] brk_len_q;
    logic [7:0] shreg_q;
    logic       par_q;
    logic       stop2_q;
    logic       brk_pend_q;
    logic       brk_req;
    logic       bit_end;

    always_comb cur = decode_cfg(cfg_i);

    assign brk_req = brk_pend_q | cur.brk;
    assign bit_end = tick_i && (sub_q == LAST_SUB);
    assign pop_o   = tick_i && (state_q == ST_IDLE) && !q_empty_i;
    assign idle_o  = (state_q == ST_IDLE);
    assign block_o = brk_req || (state_q == ST_BREAK);

    // Line level chosen from the current state
    always_comb begin
        case (state_q)
            ST_START: txd_o = 1'b0;
            ST_DATA:  txd_o = shreg_q[0];
            ST_PAR:   txd_o = par_q;
            ST_BREAK: txd_o = 1'b0;
            default:  txd_o = 1'b1;
        endcase
    end

    // Frame sequencing, bit counting and break latching
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cfg_q      <= '0;
            sub_q      <= '0;
            bit_q      <= '0;
            brk_len_q  <= '0;
            shreg_q    <= '0;
            par_q      <= 1'b0;
            stop2_q    <= 1'b0;
            brk_pend_q <= 1'b0;
        end else begin
            if (cur.brk) brk_pend_q <= 1'b1;
            if (tick_i) begin
                if (state_q == ST_IDLE) sub_q <= '0;
                else                    sub_q <= sub_q + 4'd1;
            end
            case (state_q)
                ST_IDLE: begin
                    if (tick_i) begin
                        if (brk_req && q_empty_i) begin
                            state_q   <= ST_BREAK;
                            brk_len_q <= frame_bits(cur);
                            bit_q     <= '0;
                        end else if (!q_empty_i) begin
                            state_q <= ST_START;
                            cfg_q   <= cur;
                            shreg_q <= q_data_i;
                            par_q   <= parity_of(cur, q_data_i);
                        end
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        state_q <= ST_DATA;
                        bit_q   <= '0;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        shreg_q <= {1'b0, shreg_q[7:1]};
                        bit_q   <= bit_q + 4'd1;
                        if (bit_q == {2'b00, cfg_q.len_sel} + 4'd4) begin
                            state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
                            stop2_q <= 1'b0;
                        end
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        state_q <= ST_STOP;
                        stop2_q <= 1'b0;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        if (cfg_q.two_stop && !stop2_q) stop2_q <= 1'b1;
                        else                            state_q <= ST_IDLE;
                    end
                end
                ST_BREAK: begin
                    if (bit_end) begin
                        bit_q <= bit_q + 4'd1;
                        if ((bit_q + 4'd1) >= brk_len_q && !cur.brk) begin
                            state_q    <= ST_IDLE;
                            brk_pend_q <= 1'b0;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_brk.sv
// Top: divisor counter, byte queue and serializer with break generation.
// Assumes wr_en_i is a single-cycle strobe; writes when full or under break are dropped.
module uart_tx_brk #(
    parameter int DIV_W      = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic [6:0]       frame_cfg_i,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_data_i,
    output logic             txd_o,
    output logic             txq_empty_o,
    output logic             tx_idle_o
);
    localparam int BYTE_W = 8;

    logic              tick;
    logic              q_push, q_pop, q_empty, q_full;
    logic [BYTE_W-1:0] q_head;
    logic              sh_idle, sh_block;

    // Accept a byte only when there is room and no break is in progress
    always_comb q_push = wr_en_i && !q_full && !sh_block;

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .divisor_i (divisor_i),
        .tick_o    (tick)
    );

    uart_tx_fifo #(.DATA_W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (q_push),
        .din_i   (wr_data_i),
        .pop_i   (q_pop),
        .dout_o  (q_head),
        .empty_o (q_empty),
        .full_o  (q_full)
    );

    uart_tx_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .cfg_i     (frame_cfg_i),
        .q_empty_i (q_empty),
        .q_data_i  (q_head),
        .pop_o     (q_pop),
        .txd_o     (txd_o),
        .idle_o    (sh_idle),
        .block_o   (sh_block)
    );

    assign txq_empty_o = q_empty;
    assign tx_idle_o   = q_empty && sh_idle;
endmodule

// File: rtl/uart_tx_brk_chk.sv
// Port-level property checker for the serial transmitter, bound to the top.
// Assumes synchronous active-low reset on rst_n.
module uart_tx_brk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] frame_cfg_i,
    input logic       wr_en_i,
    input logic       txd_o,
    input logic       txq_empty_o,
    input logic       tx_idle_o
);
    // R5
    idle_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle_o |-> txq_empty_o);

    // R5
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle_o |-> txd_o);

    // R6
    fill_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txq_empty_o) |-> $past(wr_en_i));

    // R9
    brk_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && frame_cfg_i[6] && txq_empty_o) |=> txq_empty_o);
endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_cfg_i (frame_cfg_i),
    .wr_en_i     (wr_en_i),
    .txd_o       (txd_o),
    .txq_empty_o (txq_empty_o),
    .tx_idle_o   (tx_idle_o)
);

// File: tb/uart_tx_brk_tb.sv
module uart_tx_brk_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'd3;
    logic [6:0]  cfg = 7'h03;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        txd, txq_empty, tx_idle;

    int n_chk = 0;
    int n_bad = 0;
    int div_cur = 3;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    uart_tx_brk u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .divisor_i   (divisor),
        .frame_cfg_i (cfg),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .txd_o       (txd),
        .txq_empty_o (txq_empty),
        .tx_idle_o   (tx_idle)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nbits(input logic [6:0] c);
        return 7 + int'(c[1:0]) + int'(c[3]) + int'(c[2]);
    endfunction

    function automatic logic [11:0] exp_frame(input logic [6:0] c, input logic [7:0] b);
        logic [11:0] v = '1;
        int idx = 1;
        int len = 5 + int'(c[1:0]);
        int ones = 0;
        v[0] = 1'b0;
        for (int i = 0; i < len; i++) begin
            v[idx] = b[i];
            ones += int'(b[i]);
            idx++;
        end
        if (c[3]) begin
            if (c[5]) v[idx] = ~c[4];
            else      v[idx] = c[4] ? logic'(ones % 2) : logic'((ones + 1) % 2);
        end
        return v;
    endfunction

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_fall(input string req, output bit ok);
        int n = 0;
        ok = 1'b1;
        while (txd !== 1'b0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) begin
            ok = 1'b0;
            check(1'b0, req, 1, 0);
        end
    endtask

    // Receive one frame from the start edge and compare all its bits
    task automatic expect_frame(input logic [6:0] c, input logic [7:0] b, input string req);
        logic [11:0] got = '1;
        logic [11:0] exp = exp_frame(c, b);
        bit ok;
        int nb = nbits(c);
        wait_fall(req, ok);
        if (ok) begin
            repeat (8 * div_cur) @(negedge clk);
            got[0] = txd;
            for (int k = 1; k < nb; k++) begin
                repeat (16 * div_cur) @(negedge clk);
                got[k] = txd;
            end
            check(got == exp, req, got, exp);
        end
    endtask

    task automatic low_len(input string req, output int cnt);
        bit ok;
        cnt = 0;
        wait_fall(req, ok);
        while (txd === 1'b0 && cnt < 50000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic quiet_for(input int cycles, input string req);
        int lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check(lows == 0 && tx_idle === 1'b1, req, lows, 0);
    endtask

    task automatic wait_idle;
        int n = 0;
        while (tx_idle !== 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({txd, txq_empty, tx_idle} == 3'b111, "R1", {txd, txq_empty, tx_idle}, 3'b111);

        // R5 status flags around one frame
        wr_byte(8'hA5);
        check({txq_empty, tx_idle} == 2'b00, "R5 after write", {txq_empty, tx_idle}, 0);
        expect_frame(7'h03, 8'hA5, "R3 8N1");
        check(txq_empty == 1'b1 && tx_idle == 1'b0, "R5 last stop", {txq_empty, tx_idle}, 2'b10);
        repeat (8 * div_cur + 1) @(negedge clk);
        check({txd, txq_empty, tx_idle} == 3'b111, "R5 idle", {txd, txq_empty, tx_idle}, 3'b111);

        // R3 / R4 sweep over every format and parity combination
        for (int c = 0; c < 64; c++) begin
            logic [7:0] b = 8'((c * 37 + 11) & 8'hFF);
            cfg = 7'(c);
            wr_byte(b);
            expect_frame(7'(c), b, (c[3] ? "R4 parity sweep" : "R3 format sweep"));
            wait_idle();
        end
        cfg = 7'h03;

        // R2 bit period for several divisors, including 0
        for (int d = 0; d < 4; d++) begin
            int dv = (d == 3) ? 5 : d;
            divisor = 16'(dv);
            div_cur = (dv == 0) ? 1 : dv;
            wr_byte(8'hFF);
            low_len("R2", cnt);
            check(cnt == 16 * div_cur, "R2 start bit length", cnt, 16 * div_cur);
            wait_idle();
        end
        divisor = 16'd2;
        div_cur = 2;

        // R6 queue depth and order, overflow dropped
        wr_byte(8'h10);
        fork
            expect_frame(7'h03, 8'h10, "R6 first");
            begin
                bit ok;
                wait_fall("R6", ok);
                for (int i = 1; i <= 6; i++) wr_byte(8'(8'h10 + i));
                check(txq_empty == 1'b0, "R6 full", txq_empty, 0);
            end
        join
        for (int i = 1; i <= 4; i++) expect_frame(7'h03, 8'(8'h10 + i), "R6 order");
        repeat (8 * div_cur + 2) @(negedge clk);
        quiet_for(2 * 160 * div_cur, "R6 overflow dropped");

        // R8 minimum break for three formats with a one-clock request, R9 write dropped
        for (int t = 0; t < 3; t++) begin
            logic [6:0] f = (t == 0) ? 7'h03 : (t == 1) ? 7'h0F : 7'h00;
            cfg = f;
            @(negedge clk);
            cfg = f | 7'h40;
            wr_en = 1'b1;
            wr_data = 8'h2A;
            @(negedge clk);
            cfg = f;
            wr_en = 1'b0;
            check(txq_empty == 1'b1, "R9 write under break", txq_empty, 1);
            low_len("R8", cnt);
            check(cnt == nbits(f) * 16 * div_cur, "R8 min break", cnt, nbits(f) * 16 * div_cur);
            quiet_for(2 * 16 * nbits(f) * div_cur, "R9 nothing after break");
        end

        // R9 write during active break
        cfg = 7'h43;
        @(negedge clk);
        cfg = 7'h03;
        begin
            bit ok;
            wait_fall("R9", ok);
        end
        wr_byte(8'h2A);
        check(txq_empty == 1'b1, "R9 write during break", txq_empty, 1);
        wait_idle();
        quiet_for(2 * 160 * div_cur, "R9 discarded byte");

        // R7 long break ends on a bit boundary after release
        cfg = 7'h43;
        fork
            low_len("R7", cnt);
            begin
                bit ok;
                wait_fall("R7", ok);
                repeat (400 * div_cur) @(negedge clk);
                cfg = 7'h03;
            end
        join
        check(cnt >= 400 * div_cur && cnt % (16 * div_cur) == 0 && cnt <= 432 * div_cur,
              "R7 held break", cnt, 416 * div_cur);

        // R7 queued bytes drain before break starts
        wait_idle();
        wr_byte(8'h5C);
        wr_byte(8'hC3);
        cfg = 7'h43;
        @(negedge clk);
        cfg = 7'h03;
        expect_frame(7'h03, 8'h5C, "R7 drain first");
        expect_frame(7'h03, 8'hC3, "R7 drain second");
        low_len("R7", cnt);
        check(cnt == 160 * div_cur, "R7 break after drain", cnt, 160 * div_cur);
        wait_idle();
        check({txd, tx_idle} == 2'b11, "R7 idle after break", {txd, tx_idle}, 2'b11);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule